// File: doc/BRIEF.md
# Eight-Stage Pipeline Run/Stall/Slip Controller

This block decides, cycle by cycle, which stages of an eight-stage in-order pipeline may advance. The stages are numbered 0 to 7 in flow order: instruction fetch first half (0), instruction fetch second half (1), register read and decode (2), execute (3), data access first half (4), data access second half (5), tag check (6) and write back (7). Each stage raises its own request when it finds an interlock. Caches, translation buffers and the datapath are not modelled here. They are seen only as requests that rise and later fall.

There are two kinds of request. A stall freezes the whole pipeline, and only stages 1, 2, 4 and 6 may raise one. A slip comes only from the decode stage, from any of six sources: load use, multiplier busy, divider busy, a one-cycle multiply/divide slip, long or variable shift, and FPU busy. A slip holds stages 0 to 2. Stages 3 to 7 keep moving, and the execute stage takes a bubble. When a stall clears, a fixed two-cycle restart phase runs before any stage moves again. On its last cycle, the decode stage is told to replay if the stall came from a tag-check miss, so that the dependent operation reads the corrected data. The inputs are synchronised through a two-flop reset release, and every output is decoded from registered state. A request seen at one clock edge therefore acts on the outputs from that edge on.

Top module: `pipe_stall_ctl`

## Requirements
- R1: While reset is applied, and until the first request after reset, run_o is 1 and hold_o, bubble_ex_o, restart_o and replay_rf_o are all 0.
- R2: A stall request on bit 1, 2, 4 or 6 of stall_req, sampled at an edge, sets all eight bits of hold_o from that edge for as long as any such request stays high.
- R3: A slip (any bit of slip_req high, with no stall) sets hold_o bits 0 to 2 and clears bits 3 to 7 from the next edge.
- R4: bubble_ex_o is 1 exactly in the cycles in which the slip pattern of R3 is shown.
- R5: Once every stall request has dropped, restart_o is 1 for exactly two cycles with all hold_o bits still set. After that the pipeline is released.
- R6: replay_rf_o is 1 on the second restart cycle only, and only if a bit-6 (tag-check) request was seen during that stall episode.
- R7: run_o is 1 only when no hold_o bit, no bubble and no restart is shown.
- R8: stall_req bits 0, 3, 5 and 7 are ignored: they never cause a stall.
- R9: A stall beats a slip raised in the same cycle. A stall raised during the restart phase returns the pipeline to the full freeze, and the restart starts over afterwards.
- R10: A slip request present when the second restart cycle ends leads straight into the slip pattern, with no run cycle in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| stall_req | input | 8 | Per-stage stall request; bit n belongs to stage n, and only bits 1, 2, 4 and 6 are honoured |
| slip_req | input | 6 | Decode-stage slip sources; any bit high requests a slip |
| hold_o | output | 8 | Per-stage hold; bit n high keeps stage n from advancing |
| bubble_ex_o | output | 1 | Inject an invalid entry into the execute stage |
| restart_o | output | 1 | High during the two restart cycles |
| replay_rf_o | output | 1 | Decode stage must repeat, on the last restart cycle after a tag-check stall |
| run_o | output | 1 | Whole pipeline advancing freely |

## Verification
All control is a single registered mode and a one-bit cause flag. A corrupted mode shows up at the ports on the very next cycle: a wrong hold pattern, a restart that is too short or too long, or a bubble with no slip. A lost or stuck cause flag only becomes visible on the second restart cycle, through replay_rf_o. For that reason tag-check stalls are mixed with other sources, and with stalls raised mid-restart, so that a stale flag has a chance to show.

// File: rtl/pipe_ctl_pkg.sv
package pipe_ctl_pkg;
  localparam int NSTG   = 8;
  localparam int NSLIP  = 6;
  localparam int IDX_RF = 2;
  localparam int IDX_EX = 3;
  localparam int IDX_TC = 6;
  // stages allowed to freeze the whole pipe: 1, 2, 4, 6
  localparam logic [NSTG-1:0] STALL_SRC_MASK = 8'h56;

  typedef enum logic [2:0] {
    M_RUN   = 3'd0,
    M_SLIP  = 3'd1,
    M_STALL = 3'd2,
    M_RST1  = 3'd3,
    M_RST2  = 3'd4
  } mode_e;
endpackage

// File: rtl/pipe_req_merge.sv
module pipe_req_merge #(
  parameter int              NSTG   = 8,
  parameter int              NSLIP  = 6,
  parameter int              TC_IDX = 6,
  parameter logic [NSTG-1:0] MASK   = 8'h56
) (
  input  logic [NSTG-1:0]  stall_req,
  input  logic [NSLIP-1:0] slip_req,
  output logic             stall_any,
  output logic             slip_any,
  output logic             stall_tc
);
  logic [NSTG-1:0] qualified;

  // only stages enabled by MASK may raise a full freeze
  for (genvar g = 0; g < NSTG; g++) begin : g_mask
    if (MASK[g]) begin : g_on
      assign qualified[g] = stall_req[g];
    end else begin : g_off
      assign qualified[g] = 1'b0;
    end
  end

  assign stall_any = |qualified;
  assign slip_any  = |slip_req;
  assign stall_tc  = qualified[TC_IDX];
endmodule

// File: rtl/pipe_mode_fsm.sv
module pipe_mode_fsm
  import pipe_ctl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  stall_any,
  input  logic  slip_any,
  input  logic  stall_tc,
  output mode_e mode_o,
  output logic  cause_tc_o
);
  mode_e mode_q, mode_d;
  logic  cause_q, cause_d, cause_en;

  always_comb begin
    mode_d   = mode_q;
    cause_en = stall_any;
    cause_d  = ((mode_q == M_STALL) ? cause_q : 1'b0) | stall_tc;
    if (stall_any) begin
      mode_d = M_STALL;
    end else begin
      case (mode_q)
        M_STALL: mode_d = M_RST1;
        M_RST1:  mode_d = M_RST2;
        default: mode_d = slip_any ? M_SLIP : M_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_RUN;
      cause_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      if (cause_en) cause_q <= cause_d;
    end
  end

  assign mode_o     = mode_q;
  assign cause_tc_o = cause_q;

  assert_stall_freeze_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stall_any |=> (mode_q == M_STALL));
  // R9: priority over slip and over a running restart
  assert_stall_over_slip_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_any && slip_any) |=> (mode_q != M_SLIP));
  assert_restart_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_STALL && !stall_any) |=> (mode_q == M_RST1));
  assert_restart_second_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RST1 && !stall_any) |=> (mode_q == M_RST2));
  assert_slip_after_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RST2 && !stall_any && slip_any) |=> (mode_q == M_SLIP));
endmodule

// File: rtl/pipe_hold_gen.sv
module pipe_hold_gen
  import pipe_ctl_pkg::*;
#(
  parameter int NSTG   = 8,
  parameter int RF_IDX = 2
) (
  input  mode_e           mode_i,
  input  logic            cause_tc_i,
  output logic [NSTG-1:0] hold_o,
  output logic            bubble_o,
  output logic            restart_o,
  output logic            replay_o,
  output logic            run_o
);
  logic frozen, slipping;

  assign frozen    = (mode_i == M_STALL) || (mode_i == M_RST1) || (mode_i == M_RST2);
  assign slipping  = (mode_i == M_SLIP);
  assign bubble_o  = slipping;
  assign restart_o = (mode_i == M_RST1) || (mode_i == M_RST2);
  assign replay_o  = (mode_i == M_RST2) && cause_tc_i;
  assign run_o     = (mode_i == M_RUN);

  // stages up to decode hold on a slip; later ones only on a freeze
  for (genvar g = 0; g < NSTG; g++) begin : g_hold
    if (g <= RF_IDX) begin : g_up
      assign hold_o[g] = frozen | slipping;
    end else begin : g_down
      assign hold_o[g] = frozen;
    end
  end
endmodule

// File: rtl/pipe_stall_ctl.sv
module pipe_stall_ctl
  import pipe_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSTG-1:0]  stall_req,
  input  logic [NSLIP-1:0] slip_req,
  output logic [NSTG-1:0]  hold_o,
  output logic             bubble_ex_o,
  output logic             restart_o,
  output logic             replay_rf_o,
  output logic             run_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       stall_any, slip_any, stall_tc, cause_tc;
  mode_e      mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pipe_req_merge #(
    .NSTG(NSTG), .NSLIP(NSLIP), .TC_IDX(IDX_TC), .MASK(STALL_SRC_MASK)
  ) u_merge (
    .stall_req(stall_req), .slip_req(slip_req),
    .stall_any(stall_any), .slip_any(slip_any), .stall_tc(stall_tc)
  );

  pipe_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_int_n),
    .stall_any(stall_any), .slip_any(slip_any), .stall_tc(stall_tc),
    .mode_o(mode), .cause_tc_o(cause_tc)
  );

  pipe_hold_gen #(.NSTG(NSTG), .RF_IDX(IDX_RF)) u_hold (
    .mode_i(mode), .cause_tc_i(cause_tc),
    .hold_o(hold_o), .bubble_o(bubble_ex_o), .restart_o(restart_o),
    .replay_o(replay_rf_o), .run_o(run_o)
  );

  assert_bubble_shape_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    bubble_ex_o |-> (hold_o[IDX_RF] && !hold_o[IDX_EX] && !restart_o));
  assert_restart_frozen_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    restart_o |-> (&hold_o));
  assert_replay_inside_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    replay_rf_o |-> restart_o);
  assert_replay_last_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    replay_rf_o |=> !restart_o);
  assert_run_free_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    run_o |-> (hold_o == '0 && !bubble_ex_o && !restart_o));
  assert_one_status_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({run_o, bubble_ex_o, restart_o}));
endmodule

// File: tb/pipe_stall_ctl_tb.sv
module pipe_stall_ctl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] stall_req = '0;
  logic [5:0] slip_req = '0;
  logic [7:0] hold_o;
  logic       bubble_ex_o, restart_o, replay_rf_o, run_o;

  int errors = 0;
  int checks = 0;

  // behavioural reference state
  bit stalled, slipping, tcflag;
  int rleft;
  int rcnt;

  always #4 clk = ~clk;

  pipe_stall_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .stall_req(stall_req), .slip_req(slip_req),
    .hold_o(hold_o), .bubble_ex_o(bubble_ex_o), .restart_o(restart_o),
    .replay_rf_o(replay_rf_o), .run_o(run_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  // reference model, advanced on each edge
  always @(posedge clk) begin
    if (!rst_n) begin
      rcnt = 0; stalled = 0; slipping = 0; tcflag = 0; rleft = 0;
    end else if (rcnt < 2) begin
      rcnt++;
    end else begin
      bit st;
      st = (stall_req[1] | stall_req[2] | stall_req[4] | stall_req[6]); // R8: others ignored
      if (st) begin
        tcflag   = (stalled ? tcflag : 1'b0) | stall_req[6];
        stalled  = 1; rleft = 0; slipping = 0;
      end else if (stalled) begin
        stalled = 0; rleft = 2;
      end else if (rleft == 2) begin
        rleft = 1;
      end else begin
        rleft = 0; slipping = (slip_req != 0);
      end
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R1 hold", hold_o, 8'h00);
      chk("R1 run", {7'b0, run_o}, 8'h01);
      chk("R1 restart", {7'b0, restart_o}, 8'h00);
      chk("R1 bubble", {7'b0, bubble_ex_o}, 8'h00);
      chk("R1 replay", {7'b0, replay_rf_o}, 8'h00);
    end else begin
      logic [7:0] eh;
      bit frz;
      frz = stalled || (rleft > 0);
      eh  = frz ? 8'hFF : (slipping ? 8'h07 : 8'h00);
      chk("R2/R3 hold", hold_o, eh);
      chk("R4 bubble", {7'b0, bubble_ex_o}, {7'b0, (slipping && !frz)});
      chk("R5 restart", {7'b0, restart_o}, {7'b0, (rleft > 0)});
      chk("R6 replay", {7'b0, replay_rf_o}, {7'b0, (rleft == 1 && tcflag)});
      chk("R7 run", {7'b0, run_o}, {7'b0, (!frz && !slipping)});
    end
  end

  task automatic drive(input logic [7:0] st, input logic [5:0] sl, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      stall_req = st;
      slip_req  = sl;
    end
  endtask

  bit done = 0;

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    drive(8'h00, 6'h00, 4);                       // R1 after release
    drive(8'h00, 6'h01, 3); drive(8'h00, 6'h00, 3); // R3, R4
    drive(8'h02, 6'h00, 3); drive(8'h00, 6'h00, 5); // R2, R5 stage 1
    drive(8'h40, 6'h00, 2); drive(8'h00, 6'h00, 5); // R6 tag-check stall
    drive(8'h10, 6'h00, 2); drive(8'h00, 6'h00, 5); // R6 no replay
    drive(8'h04, 6'h20, 2); drive(8'h00, 6'h00, 5); // R9 stall beats slip
    drive(8'hA9, 6'h00, 4); drive(8'h00, 6'h00, 2); // R8 ignored bits
    drive(8'h04, 6'h00, 2); drive(8'h00, 6'h00, 1);
    drive(8'h10, 6'h00, 1); drive(8'h00, 6'h00, 5); // R9 stall inside restart
    drive(8'h10, 6'h08, 2); drive(8'h00, 6'h08, 5); // R10 slip at restart end
    drive(8'h00, 6'h00, 2);
    drive(8'h40, 6'h00, 1); drive(8'h04, 6'h00, 2); drive(8'h00, 6'h00, 5); // R6 mixed episode
    drive(8'h40, 6'h00, 1); drive(8'h00, 6'h00, 1);
    drive(8'h02, 6'h00, 1); drive(8'h00, 6'h00, 5); // R6 flag cleared by new episode
    for (int k = 0; k < 600; k++) begin
      logic [7:0] st;
      logic [5:0] sl;
      st = (($urandom % 5) == 0) ? 8'($urandom) : 8'h00;
      sl = (($urandom % 4) == 0) ? 6'($urandom) : 6'h00;
      drive(st, sl, 1);
    end
    drive(8'h00, 6'h00, 4);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
    end
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule